// File: doc/BRIEF.md
# Synchronous Host Register Port

This block is the slave side of a clocked microprocessor bus. An external processor uses it to reach a small set of internal registers and a 16-word data buffer. The bus has a 7-bit address, an active-low chip select, an active-low write strobe that is sampled on the clock, and an active-low output enable that acts without the clock. The bidirectional data bus is split into an input word, an output word and an output-enable flag; the pad ring combines them into a tristate bus.

Writes are recognised by a strobe-shape detector. Reads follow a fixed sequence that is timed from the falling edge of the chip select. Two status outputs go to the host. `buf_rdy` shows whether the buffer can be used in the direction that software has chosen. `irq` reports sticky fault flags for buffer overflow and buffer underflow. Each flag stays set until software clears it.

The write detector (`hb_wstrobe`) has three states:
- `W_HOLD`: no fresh high sample has been seen. This is the reset state, and it is also entered when the strobe stays low too long or falls while the chip select is high.
- `W_ARMED`: the last sample was high.
- `W_LOW`: exactly one low sample has been taken with the chip select low. The address and data are captured on that edge.

Its transitions are:
- `W_HOLD` goes to `W_ARMED` on a high sample.
- `W_ARMED` goes to `W_LOW` on a low sample with chip select low, or to `W_HOLD` on a low sample with chip select high.
- `W_LOW` goes to `W_ARMED` on a high sample, and this edge commits the write. It goes to `W_HOLD` on a second low sample.

The read sequencer (`hb_rdseq`) has three states:
- `R_IDLE`: waiting for a read to start.
- `R_SETUP`: a chip-select fall has been seen with the write strobe high, and the address is latched.
- `R_HOLD`: read data is loaded.

Its transitions are:
- `R_IDLE` goes to `R_SETUP` when it sees that chip-select fall.
- `R_SETUP` goes to `R_HOLD` at the next edge if chip select is still low; this edge is the fetch. Otherwise it aborts to `R_IDLE`.
- `R_HOLD` goes to `R_IDLE` when chip select is sampled high. That edge completes the read.

Top module: `hostbus_regport`

## Requirements
- R1: A write takes effect only at a rising edge where `we_n` is sampled high, the previous edge sampled it low with `ce_n` low, and the edge before that sampled it high. The address and data stored are those sampled at the low edge.
- R2: If `we_n` is sampled low on two or more consecutive edges, or is sampled low while `ce_n` is high, no write takes place.
- R3: A read starts at an edge that samples `ce_n` low after it was high, with `we_n` high. From the next rising edge, `dout` holds the addressed register value; before that edge it keeps its previous value. The value stays until the next read fetch.
- R4: `dout_en` is high exactly when both `oe_n` and `ce_n` are low. It does not depend on the clock.
- R5: Register map:
  - 0x00 is the control register. Bit 0 is the interrupt enable and bit 1 is the buffer direction (1 = write). On read, bits 9:8 hold the pending flags for underflow and overflow.
  - 0x01 is read-only and holds the buffer fill count in bits 4:0.
  - 0x02 is a read/write scratch word.
  - Unmapped addresses read 0 and ignore writes.
- R6: At address 0x10, each write pushes one word into the buffer. Each completed read pops one word and returns the oldest word, in first-in first-out order.
- R7: In read direction, `buf_rdy` is high when the buffer holds at least one word. In write direction, it is high when the buffer holds fewer than 16 words.
- R8: A push to a full buffer is dropped and sets pending bit 8 (overflow). A read of the empty buffer returns 0 and sets pending bit 9 (underflow) when the read completes.
- R9: `irq` is high while the interrupt enable is set and any pending bit is set. Pending bits are sticky. Only a control write with a 1 in bit 8 or bit 9 clears the corresponding bit.
- R10: `irq` is low whenever the interrupt enable is 0, whatever is pending.
- R11: After reset, `irq`, `buf_rdy`, `dout` and all registers are 0, and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 7 | Register address |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low, sampled on the clock |
| oe_n | input | 1 | Output enable, active low, not clocked |
| din | input | 16 | Data bus, inbound half |
| dout | output | 16 | Data bus, outbound half |
| dout_en | output | 1 | Drive enable for the data pads |
| buf_rdy | output | 1 | Buffer usable in the selected direction |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest state to reach from the ports is the overflow flag. Reaching it takes switching the buffer to write direction, making sixteen well-formed strobe pulses and then one more. The bench does this with a loop of write tasks, then checks that the dropped word never comes out when it drains the buffer. The rejected strobe shapes are driven by hand, outside the write task: a strobe held low for two edges, and a strobe that falls while chip select is high. Read latency is checked by sampling `dout` one edge after the chip-select fall, when it must still show the previous fetch.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;
    typedef enum logic [1:0] {W_HOLD, W_ARMED, W_LOW} wstate_t;
    typedef enum logic [1:0] {R_IDLE, R_SETUP, R_HOLD} rstate_t;

    localparam int ADR_CTRL    = 'h00;
    localparam int ADR_FILL    = 'h01;
    localparam int ADR_SCRATCH = 'h02;
    localparam int ADR_BUF     = 'h10;

    localparam int BIT_IEN  = 0;
    localparam int BIT_DIR  = 1;
    localparam int BIT_OVF  = 8;
    localparam int BIT_UDF  = 9;
endpackage

// File: rtl/hb_wstrobe.sv
module hb_wstrobe
    import hostbus_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          commit,
    output logic [AW-1:0] c_addr,
    output logic [DW-1:0] c_data
);
    wstate_t st, nxt;

    always_comb begin
        nxt = st;
        unique case (st)
            W_HOLD:  if (we_n) nxt = W_ARMED;
            W_ARMED: if (!we_n) nxt = ce_n ? W_HOLD : W_LOW;
            W_LOW:   nxt = we_n ? W_ARMED : W_HOLD;
            default: nxt = W_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= W_HOLD;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_addr <= '0;
            c_data <= '0;
        end else if (st == W_ARMED && !we_n && !ce_n) begin
            c_addr <= addr;
            c_data <= din;
        end
    end

    assign commit = (st == W_LOW) && we_n;
endmodule

// File: rtl/hb_rdseq.sv
module hb_rdseq
    import hostbus_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output logic          fetch,
    output logic          done,
    output logic [AW-1:0] r_addr
);
    rstate_t st, nxt;
    logic    ce_q;
    logic    start;

    assign start = (st == R_IDLE) && !ce_n && ce_q && we_n;

    always_comb begin
        nxt = st;
        unique case (st)
            R_IDLE:  if (start) nxt = R_SETUP;
            R_SETUP: nxt = ce_n ? R_IDLE : R_HOLD;
            R_HOLD:  if (ce_n) nxt = R_IDLE;
            default: nxt = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= R_IDLE;
            ce_q   <= 1'b1;
            r_addr <= '0;
        end else begin
            st   <= nxt;
            ce_q <= ce_n;
            if (start) r_addr <= addr;
        end
    end

    assign fetch = (st == R_SETUP) && !ce_n;
    assign done  = (st == R_HOLD) && ce_n;
endmodule

// File: rtl/hb_fifo.sv
module hb_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = empty ? '0 : mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/hostbus_regport.sv
module hostbus_regport
    import hostbus_pkg::*;
#(
    parameter int AW    = 7,
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          buf_rdy,
    output logic          irq
);
    logic          wr_commit, rd_fetch, rd_done;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] wr_data, fifo_head, rmux, rdata_q, scratch_q;
    logic [CW-1:0] fifo_cnt;
    logic          fifo_full, fifo_empty;
    logic          ien_q, dir_q;
    logic [1:0]    pend_q;
    logic          push, pop, ovf, udf, clr_hit;

    hb_wstrobe #(.AW(AW), .DW(DW)) u_wr (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .din(din), .commit(wr_commit), .c_addr(wr_addr), .c_data(wr_data)
    );

    hb_rdseq #(.AW(AW)) u_rd (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .fetch(rd_fetch), .done(rd_done), .r_addr(rd_addr)
    );

    assign push    = wr_commit && (wr_addr == AW'(ADR_BUF));
    assign pop     = rd_done && (rd_addr == AW'(ADR_BUF));
    assign ovf     = push && fifo_full;
    assign udf     = pop && fifo_empty;
    assign clr_hit = wr_commit && (wr_addr == AW'(ADR_CTRL));

    hb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .wdata(wr_data),
        .head(fifo_head), .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q     <= 1'b0;
            dir_q     <= 1'b0;
            scratch_q <= '0;
            pend_q    <= '0;
        end else begin
            if (clr_hit) begin
                ien_q <= wr_data[BIT_IEN];
                dir_q <= wr_data[BIT_DIR];
            end
            if (wr_commit && wr_addr == AW'(ADR_SCRATCH)) scratch_q <= wr_data;
            pend_q <= (pend_q & ~(clr_hit ? {wr_data[BIT_UDF], wr_data[BIT_OVF]} : 2'b00))
                      | {udf, ovf};
        end
    end

    always_comb begin
        rmux = '0;
        unique case (rd_addr)
            AW'(ADR_CTRL): begin
                rmux[BIT_IEN] = ien_q;
                rmux[BIT_DIR] = dir_q;
                rmux[BIT_OVF] = pend_q[0];
                rmux[BIT_UDF] = pend_q[1];
            end
            AW'(ADR_FILL):    rmux = {{(DW-CW){1'b0}}, fifo_cnt};
            AW'(ADR_SCRATCH): rmux = scratch_q;
            AW'(ADR_BUF):     rmux = fifo_head;
            default:          rmux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rdata_q <= '0;
        else if (rd_fetch) rdata_q <= rmux;
    end

    assign dout    = rdata_q;
    assign dout_en = !oe_n && !ce_n;
    assign buf_rdy = dir_q ? !fifo_full : !fifo_empty;
    assign irq     = ien_q && (pend_q != 2'b00);
endmodule

// File: rtl/hb_checker.sv
module hb_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          we_n,
    input logic          irq,
    input logic          commit,
    input logic          fetch,
    input logic          ien,
    input logic          clr_hit,
    input logic [1:0]    pend,
    input logic [CW-1:0] count
);
    AST_WR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (we_n && !$past(we_n) && $past(we_n, 2))); // R1
    AST_WR_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !$past(ce_n)); // R2
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |-> (!ce_n && !$past(ce_n) && $past(ce_n, 2))); // R3
    AST_BUF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R6
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_hit) |-> ((pend & $past(pend)) == $past(pend))); // R9
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq); // R10
endmodule

bind hostbus_regport hb_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .irq(irq),
    .commit(wr_commit), .fetch(rd_fetch), .ien(ien_q), .clr_hit(clr_hit),
    .pend(pend_q), .count(fifo_cnt)
);

// File: tb/sim_hostbus_regport.sv
module sim_hostbus_regport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  addr = '0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        dout_en, buf_rdy, irq;
    int          n_run = 0, n_fail = 0;
    logic        finished = 1'b0;

    always #10 clk = ~clk;

    hostbus_regport u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en),
        .buf_rdy(buf_rdy), .irq(irq)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [15:0] d);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        tick();
        we_n = 1'b1; ce_n = 1'b1; din = 16'hxxxx;
        tick();
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [15:0] d);
        addr = a; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
        tick();
        chk("R4 no drive with oe high", {15'd0, dout_en}, 16'd0);
        oe_n = 1'b0;
        tick();
        d = dout;
        tick();
        ce_n = 1'b1; oe_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R11 irq", {15'd0, irq}, 16'd0);
        chk("R11 buf_rdy", {15'd0, buf_rdy}, 16'd0);
        chk("R11 dout", dout, 16'd0);
        bus_read(7'h00, v); chk("R11 ctrl", v, 16'h0000);
        bus_read(7'h01, v); chk("R11 fill", v, 16'h0000);
    endtask

    task automatic t_scratch();
        logic [15:0] v;
        bus_write(7'h02, 16'hA5C3);
        bus_read(7'h02, v); chk("R1 R5 scratch", v, 16'hA5C3);
        oe_n = 1'b0; ce_n = 1'b1;
        tick();
        chk("R4 ce high", {15'd0, dout_en}, 16'd0);
        oe_n = 1'b1;
    endtask

    task automatic t_latency();
        logic [15:0] v;
        bus_write(7'h02, 16'h1234);
        bus_read(7'h01, v);
        addr = 7'h02; ce_n = 1'b0; oe_n = 1'b0;
        tick();
        chk("R4 drive", {15'd0, dout_en}, 16'd1);
        chk("R3 old value first edge", dout, 16'h0000);
        tick();
        chk("R3 data second edge", dout, 16'h1234);
        ce_n = 1'b1; oe_n = 1'b1;
        tick();
    endtask

    task automatic t_bad_strobe();
        logic [15:0] v;
        addr = 7'h02; din = 16'hBEEF; ce_n = 1'b0; we_n = 1'b0;
        tick(); tick();
        we_n = 1'b1; ce_n = 1'b1;
        tick();
        bus_read(7'h02, v); chk("R2 long low", v, 16'h1234);
        addr = 7'h02; din = 16'hCAFE; ce_n = 1'b1; we_n = 1'b0;
        tick();
        we_n = 1'b1;
        tick();
        bus_read(7'h02, v); chk("R2 ce high", v, 16'h1234);
    endtask

    task automatic t_unmapped();
        logic [15:0] v;
        bus_write(7'h55, 16'hFFFF);
        bus_read(7'h55, v); chk("R5 unmapped", v, 16'h0000);
        bus_read(7'h02, v); chk("R5 unmapped write", v, 16'h1234);
    endtask

    task automatic t_fifo();
        logic [15:0] v;
        chk("R7 read dir empty", {15'd0, buf_rdy}, 16'd0);
        for (int i = 0; i < 3; i++) bus_write(7'h10, 16'h0A00 + 16'(i));
        chk("R7 read dir data", {15'd0, buf_rdy}, 16'd1);
        bus_read(7'h01, v); chk("R5 fill count", v, 16'd3);
        for (int i = 0; i < 3; i++) begin
            bus_read(7'h10, v); chk("R6 order", v, 16'h0A00 + 16'(i));
        end
        chk("R7 drained", {15'd0, buf_rdy}, 16'd0);
    endtask

    task automatic t_irq();
        logic [15:0] v;
        bus_write(7'h00, 16'h0002);
        chk("R7 write dir space", {15'd0, buf_rdy}, 16'd1);
        for (int i = 0; i < 16; i++) bus_write(7'h10, 16'h1000 + 16'(i));
        chk("R7 write dir full", {15'd0, buf_rdy}, 16'd0);
        bus_write(7'h10, 16'hDEAD);
        chk("R10 masked", {15'd0, irq}, 16'd0);
        bus_read(7'h00, v); chk("R8 overflow flag", v, 16'h0102);
        bus_write(7'h00, 16'h0003);
        chk("R9 irq raised", {15'd0, irq}, 16'd1);
        bus_write(7'h00, 16'h0003);
        chk("R9 sticky", {15'd0, irq}, 16'd1);
        bus_write(7'h00, 16'h0103);
        chk("R9 cleared", {15'd0, irq}, 16'd0);
        for (int i = 0; i < 16; i++) begin
            bus_read(7'h10, v); chk("R6 full drain", v, 16'h1000 + 16'(i));
        end
        bus_read(7'h10, v); chk("R8 empty read", v, 16'h0000);
        chk("R8 underflow irq", {15'd0, irq}, 16'd1);
        bus_read(7'h00, v); chk("R8 underflow flag", v, 16'h0203);
        bus_write(7'h00, 16'h0002);
        chk("R10 disabled", {15'd0, irq}, 16'd0);
        bus_write(7'h00, 16'h0203);
        chk("R9 clear underflow", {15'd0, irq}, 16'd0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_scratch();
        t_latency();
        t_bad_strobe();
        t_unmapped();
        t_fifo();
        t_irq();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule